// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer Register Bank

This block is the memory-mapped front end of a bank of down-counting timer channels. A simple request port carries one 32-bit word access per cycle. Each access targets a channel's count, reload or one of its two match words, the shared control word, or a second control word. The control word gives every channel a four-bit field: run, external clock select, zero-crossing interrupt enable and pulse mode. The bank turns changes in those fields into per-channel run, clock-select, interrupt-enable and start signals for the channel counters it instantiates.

A channel that is started loads its reload value and then counts down by one on every enabled tick. The tick is either every clock cycle or a shared external tick strobe. After zero the count wraps to the reload value. The interrupt line of the channel flips level each time the count lands on one of its match values, or on zero when the zero-crossing interrupt is enabled. Stopping takes effect before a new configuration reaches the counter. Starting takes effect only once the new configuration is in place. Pulse mode is accepted only on the upper channels.

Top module: `tmr_bank`

## Requirements
- R1: Channels 0, 1 and 2 sit at byte offsets 0x00, 0x10 and 0x20. Inside any channel window, word offset 0x0 is the count, 0x4 the reload value, 0x8 match A and 0xC match B. Every one of these words can be written and read back independently of all other words.
- R2: Channel windows at offsets 0x40 through 0x80 belong to channels 3 through 7, the channel index being (offset >> 4) - 1. They use the same word layout as R1.
- R3: Offset 0x30 holds the control word, stored and read back exactly as written. Its field for channel i is bit 4i = run, 4i+1 = external clock, 4i+2 = zero interrupt enable and 4i+3 = pulse mode. Offset 0x34 holds a second 32-bit word that is stored and read back.
- R4: An access at 0x38, at 0x3C, at any offset of 0x90 or above, or at any offset not a multiple of 4 reads zero and changes no register. It also raises `err` for exactly the cycle after the request.
- R5: Every read request is answered by `rsp_valid` high for one cycle, in the cycle after the request, with the data on `rsp_rdata`. Writes produce no response.
- R6: After reset, every register reads zero, every `irq` line is low, `pulse_mode` is zero and no channel counts.
- R7: When a control write sets a channel's run bit from 0, the count equals the reload value two edges after the write edge. On each later edge the count goes down by one on the internal clock, and it wraps from zero to the reload value.
- R8: A channel started with external clock selected in the same control write never counts on the internal clock. It decrements only on edges where `ext_tick` is high.
- R9: On each counting step, the channel's `irq` flips if the new count equals match A or match B, or if it is zero and the zero interrupt enable is set.
- R10: Once a control write clears the run bit, the count stops after the write edge and `irq` holds its level while the channel is stopped.
- R11: Setting the pulse bit of channel 0, 1 or 2 where it was clear raises `err` for one cycle and leaves that `pulse_mode` bit low. On channels 3 to 7 the bit drives `pulse_mode` without error.
- R12: A write to a channel's count word loads the counter with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| ext_tick | input | 1 | External count strobe shared by all channels |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| err | output | 1 | One-cycle flag for an illegal access or a refused pulse bit |
| irq | output | 8 | Per-channel interrupt level |
| pulse_mode | output | 8 | Per-channel accepted pulse mode |

## Verification
Register writes land on the request edge, while read data, `rsp_valid` and `err` appear one cycle after the request. The bench drives on falling edges and samples on the next falling edge, which is exactly that cycle. The counting results count edges from the control write. The reload loads on the second edge after the write, and every following edge with a tick removes one. The stopping write's own edge still counts under the old settings. The bench works out the expected frozen count and `irq` level from the number of falling edges it waited, and reads them only after the channel is stopped, so read latency cannot blur the count.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer register bank.
// Assumes a four-bit control field per channel in the shared control word.
package tmr_pkg;
    localparam int FIELD_W  = 4;   // control bits per channel
    localparam int F_RUN    = 0;   // start/stop
    localparam int F_EXT    = 1;   // external tick select
    localparam int F_ZIRQ   = 2;   // interrupt on reaching zero
    localparam int F_PULSE  = 3;   // pulse mode request

    // Word inside a channel's 16-byte window
    typedef enum logic [1:0] {
        W_COUNT  = 2'd0,
        W_RELOAD = 2'd1,
        W_MATCHA = 2'd2,
        W_MATCHB = 2'd3
    } word_e;
endpackage

// File: rtl/tmr_ctrl.sv
// Control word holder: stores the shared control word, fans out per-channel
// settings, creates a one-cycle start strobe when a run bit rises and flags
// pulse-mode requests on channels that cannot pulse.
// Assumes NUM_CH * FIELD_W <= DW.
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DW          = 32,
    parameter int PULSE_FIRST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     ctrl_q,
    output logic [NUM_CH-1:0] run,
    output logic [NUM_CH-1:0] ext,
    output logic [NUM_CH-1:0] zirq,
    output logic [NUM_CH-1:0] start,
    output logic [NUM_CH-1:0] pulse_mode,
    output logic              pulse_err
);
    logic [NUM_CH-1:0] bad_pulse;
    logic [NUM_CH-1:0] start_q;
    logic              pulse_err_q;

    // Hold the control word exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr) ctrl_q <= wdata;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_field
        localparam int B = i * FIELD_W;
        assign run[i]  = ctrl_q[B + F_RUN];
        assign ext[i]  = ctrl_q[B + F_EXT];
        assign zirq[i] = ctrl_q[B + F_ZIRQ];

        // Start strobe for the cycle right after a rising run bit.
        always_ff @(posedge clk) begin
            if (!rst_n) start_q[i] <= 1'b0;
            else start_q[i] <= wr && wdata[B + F_RUN] && !ctrl_q[B + F_RUN];
        end

        if (i >= PULSE_FIRST) begin : g_pulse_ok
            assign pulse_mode[i] = ctrl_q[B + F_PULSE];
            assign bad_pulse[i]  = 1'b0;
        end else begin : g_pulse_no
            assign pulse_mode[i] = 1'b0;
            assign bad_pulse[i]  = wr && wdata[B + F_PULSE] && !ctrl_q[B + F_PULSE];
        end
    end

    // Register the refused-pulse flag so it lines up with bus errors.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_err_q <= 1'b0;
        else pulse_err_q <= |bad_pulse;
    end

    assign start     = start_q;
    assign pulse_err = pulse_err_q;
endmodule

// File: rtl/tmr_chan.sv
// One down-counting channel: count, reload and two match registers, plus an
// interrupt level that flips on match or zero events.
// Assumes the start strobe lasts one cycle and run is already high with it.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ext,
    input  logic          zirq,
    input  logic          start,
    input  logic          ext_tick,
    input  logic          wr,
    input  word_e         wr_word,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] reload_o,
    output logic [CW-1:0] match_a_o,
    output logic [CW-1:0] match_b_o,
    output logic          irq_o
);
    logic [CW-1:0] cnt_q, reload_q, ma_q, mb_q, cnt_nxt;
    logic          irq_q, cnt_wr, step, hit;

    assign cnt_wr  = wr && (wr_word == W_COUNT);
    // A counting step: running, not loading, tick present, no bus override.
    assign step    = run && !start && !cnt_wr && (ext ? ext_tick : 1'b1);
    assign cnt_nxt = (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    assign hit     = (cnt_nxt == ma_q) || (cnt_nxt == mb_q) ||
                     (zirq && cnt_nxt == '0);

    // Settings registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ma_q     <= '0;
            mb_q     <= '0;
        end else if (wr) begin
            case (wr_word)
                W_RELOAD: reload_q <= wdata;
                W_MATCHA: ma_q     <= wdata;
                W_MATCHB: mb_q     <= wdata;
                default:  ;
            endcase
        end
    end

    // Counter: start load first, then bus load, then counting step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (start)  cnt_q <= reload_q;
        else if (cnt_wr) cnt_q <= wdata;
        else if (step)   cnt_q <= cnt_nxt;
    end

    // Interrupt level flips on each step that lands on an event value.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (step && hit) irq_q <= !irq_q;
    end

    assign cnt_o     = cnt_q;
    assign reload_o  = reload_q;
    assign match_a_o = ma_q;
    assign match_b_o = mb_q;
    assign irq_o     = irq_q;
endmodule

// File: rtl/tmr_bank.sv
// Timer bank top: decodes word accesses into channel, control and second
// control registers, returns read data one cycle later and flags illegal
// offsets. The control block sits at window slot 3, so channel windows
// above it are shifted down by one.
// Assumes AW > 8 and NUM_CH + 1 <= 15 so every window fits in 8 offset bits.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DW          = 32,
    parameter int AW          = 12,
    parameter int PULSE_FIRST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              ext_tick,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              err,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] pulse_mode
);
    localparam int          CHW       = $clog2(NUM_CH);
    localparam logic [3:0]  CTRL_SLOT = 4'd3;
    localparam logic [3:0]  LAST_SLOT = 4'(NUM_CH);
    localparam logic [7:0]  OFF_CTRL  = 8'h30;
    localparam logic [7:0]  OFF_CTRL2 = 8'h34;

    logic [7:0]        off;
    logic [3:0]        slot, ch_full;
    logic [CHW-1:0]    ch_idx;
    word_e             word_sel;
    logic              in_range, is_ctrl, is_ctrl2, is_chan, illegal;
    logic              rsp_valid_q, err_q, pulse_err;
    logic [DW-1:0]     rdata_q, rd_mux, ctrl_q, ctrl2_q;
    logic [NUM_CH-1:0] run_v, ext_v, zirq_v, start_v;
    logic [DW-1:0]     cnt_a [NUM_CH];
    logic [DW-1:0]     rel_a [NUM_CH];
    logic [DW-1:0]     ma_a  [NUM_CH];
    logic [DW-1:0]     mb_a  [NUM_CH];

    // Address decode.
    assign off      = req_addr[7:0];
    assign slot     = off[7:4];
    assign word_sel = word_e'(off[3:2]);
    assign in_range = (req_addr[1:0] == 2'b00) && (req_addr[AW-1:8] == '0);
    assign is_ctrl  = in_range && (off == OFF_CTRL);
    assign is_ctrl2 = in_range && (off == OFF_CTRL2);
    assign is_chan  = in_range && (slot != CTRL_SLOT) && (slot <= LAST_SLOT);
    assign ch_full  = (slot < CTRL_SLOT) ? slot : slot - 4'd1;
    assign ch_idx   = ch_full[CHW-1:0];
    assign illegal  = !(is_ctrl || is_ctrl2 || is_chan);

    tmr_ctrl #(
        .NUM_CH(NUM_CH), .DW(DW), .PULSE_FIRST(PULSE_FIRST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (req_valid && req_write && is_ctrl),
        .wdata     (req_wdata),
        .ctrl_q    (ctrl_q),
        .run       (run_v),
        .ext       (ext_v),
        .zirq      (zirq_v),
        .start     (start_v),
        .pulse_mode(pulse_mode),
        .pulse_err (pulse_err)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_chan #(.CW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_v[i]),
            .ext      (ext_v[i]),
            .zirq     (zirq_v[i]),
            .start    (start_v[i]),
            .ext_tick (ext_tick),
            .wr       (req_valid && req_write && is_chan && (ch_idx == CHW'(i))),
            .wr_word  (word_sel),
            .wdata    (req_wdata),
            .cnt_o    (cnt_a[i]),
            .reload_o (rel_a[i]),
            .match_a_o(ma_a[i]),
            .match_b_o(mb_a[i]),
            .irq_o    (irq[i])
        );
    end

    // Second control word: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl2_q <= '0;
        else if (req_valid && req_write && is_ctrl2) ctrl2_q <= req_wdata;
    end

    // Read data selection for the current request.
    always_comb begin
        rd_mux = '0;
        if (is_ctrl)       rd_mux = ctrl_q;
        else if (is_ctrl2) rd_mux = ctrl2_q;
        else if (is_chan) begin
            case (word_sel)
                W_COUNT:  rd_mux = cnt_a[ch_idx];
                W_RELOAD: rd_mux = rel_a[ch_idx];
                W_MATCHA: rd_mux = ma_a[ch_idx];
                default:  rd_mux = mb_a[ch_idx];
            endcase
        end
    end

    // Response and error registers, due one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
            err_q       <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid && !req_write;
            if (req_valid && !req_write) rdata_q <= rd_mux;
            err_q       <= req_valid && illegal;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rdata_q;
    assign err       = err_q || pulse_err;
endmodule

// File: rtl/tmr_bank_chk.sv
// Property checker for the timer bank, bound to every tmr_bank instance.
// Assumes the fixed offset map with legal offsets below 0x90.
module tmr_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int DW     = 32,
    parameter int AW     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic              rsp_valid,
    input logic [DW-1:0]     rsp_rdata,
    input logic              err,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] ch_run
);
    logic bad_addr;
    // Independent statement of the legal offsets.
    assign bad_addr = (req_addr[1:0] != 2'b00) || (req_addr >= AW'(12'h090)) ||
                      (req_addr == AW'(12'h038)) || (req_addr == AW'(12'h03C));

    assert_rsp_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_only_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_bad_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && bad_addr) |=> (rsp_rdata == '0));

    assert_bad_access_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_addr) |=> err);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hold
        assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[i] |=> $stable(irq[i]));
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .err      (err),
    .irq      (irq),
    .ch_run   (run_v)
);

// File: tb/tmr_bank_bench.sv
// Bench for the timer bank: register sweeps, illegal offsets, control
// decoding and counting runs with expected values worked out from edges.
module tmr_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, ext_tick = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, err;
    logic [31:0] rsp_rdata;
    logic [7:0]  irq, pulse_mode;
    int          checks = 0, fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_bank u_tmr_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ext_tick(ext_tick),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err),
        .irq(irq), .pulse_mode(pulse_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ch_addr(input int ch, input int w);
        int base = (ch < 3) ? ch * 16 : (ch + 1) * 16;
        return 12'(base + w * 4);
    endfunction

    function automatic logic [31:0] pat(input int ch, input int w);
        return 32'hA500_0000 | 32'(ch << 12) | 32'(w << 8) | 32'(ch * 7 + w + 1);
    endfunction

    // One write; returns err as seen one cycle later.
    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        e = err;
        chk("R5 no response to write", {31'd0, rsp_valid}, 32'd0);
    endtask

    // One read; returns data and err one cycle later, checks rsp_valid.
    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; e = err;
        chk("R5 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        logic [11:0] bad [7];
        bad = '{12'h038, 12'h03C, 12'h090, 12'h0F0, 12'h035, 12'h102, 12'h200};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state on every register and output.
        chk("R6 irq after reset", {24'd0, irq}, 32'd0);
        chk("R6 pulse_mode after reset", {24'd0, pulse_mode}, 32'd0);
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) begin
                rd(ch_addr(c, w), d, e);
                chk("R6 channel word after reset", d, 32'd0);
            end
        rd(12'h030, d, e); chk("R6 control after reset", d, 32'd0);
        rd(12'h034, d, e); chk("R6 control2 after reset", d, 32'd0);
        chk("R6 no err on legal read", {31'd0, e}, 32'd0);

        // R1/R2/R12: write every word with a unique value, then read all back.
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) begin
                wr(ch_addr(c, w), pat(c, w), e);
                chk("R1 R2 no err on legal write", {31'd0, e}, 32'd0);
            end
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) begin
                rd(ch_addr(c, w), d, e);
                if (c < 3) chk(w == 0 ? "R12 count load (low)" : "R1 low window word", d, pat(c, w));
                else       chk(w == 0 ? "R12 count load (high)" : "R2 shifted window word", d, pat(c, w));
            end

        // R3: second control word storage.
        wr(12'h034, 32'h5A5A_C3C3, e);
        rd(12'h034, d, e); chk("R3 control2 readback", d, 32'h5A5A_C3C3);

        // R4: illegal offsets read zero, flag err, change nothing.
        foreach (bad[k]) begin
            wr(bad[k], 32'hFFFF_FFFF, e);
            chk("R4 err on illegal write", {31'd0, e}, 32'd1);
            rd(bad[k], d, e);
            chk("R4 illegal read is zero", d, 32'd0);
            chk("R4 err on illegal read", {31'd0, e}, 32'd1);
        end
        for (int c = 0; c < 8; c++)
            for (int w = 0; w < 4; w++) begin
                rd(ch_addr(c, w), d, e);
                chk("R4 channel word untouched", d, pat(c, w));
            end
        rd(12'h034, d, e); chk("R4 control2 untouched", d, 32'h5A5A_C3C3);
        rd(12'h030, d, e); chk("R4 control untouched", d, 32'd0);

        // R11: pulse bit on channel 2 is refused, on channel 5 accepted.
        wr(12'h030, 32'h1 << (2 * 4 + 3), e);
        chk("R11 err for low-channel pulse", {31'd0, e}, 32'd1);
        chk("R11 low-channel pulse_mode stays low", {24'd0, pulse_mode}, 32'd0);
        rd(12'h030, d, e); chk("R3 control stored as written", d, 32'h1 << 11);
        wr(12'h030, 32'h1 << (5 * 4 + 3), e);
        chk("R11 no err for upper pulse", {31'd0, e}, 32'd0);
        chk("R11 upper pulse_mode", {24'd0, pulse_mode}, 32'h20);
        wr(12'h030, 32'h0, e);

        // R7/R9/R10: channel 0, reload 10, matches 7 and 3, internal clock.
        wr(ch_addr(0, 1), 32'd10, e);
        wr(ch_addr(0, 2), 32'd7, e);
        wr(ch_addr(0, 3), 32'd3, e);
        wr(12'h030, 32'h1, e);             // start: load 2 edges later
        repeat (4) @(negedge clk);         // 4 waits + stop edge = 5 steps
        wr(12'h030, 32'h0, e);
        chk("R9 irq after passing match A", {31'd0, irq[0]}, 32'd1);
        rd(ch_addr(0, 0), d, e); chk("R7 count after 5 steps", d, 32'd5);
        repeat (6) @(negedge clk);
        rd(ch_addr(0, 0), d, e); chk("R10 count frozen while stopped", d, 32'd5);
        chk("R10 irq held while stopped", {31'd0, irq[0]}, 32'd1);

        // R7/R9: restart with zero interrupt, 12 steps wrap past zero.
        wr(12'h030, 32'h5, e);
        repeat (11) @(negedge clk);
        wr(12'h030, 32'h0, e);
        rd(ch_addr(0, 0), d, e); chk("R7 count after wrap", d, 32'd9);
        chk("R9 irq after matches and zero", {31'd0, irq[0]}, 32'd0);

        // R8: channel 1 started with external clock in the same write.
        wr(ch_addr(1, 1), 32'd20, e);
        wr(ch_addr(1, 2), 32'd0, e);
        wr(ch_addr(1, 3), 32'd0, e);
        wr(12'h030, 32'h3 << 4, e);
        repeat (5) @(negedge clk);
        ext_tick = 1'b1;
        repeat (4) @(negedge clk);
        ext_tick = 1'b0;
        repeat (3) @(negedge clk);
        wr(12'h030, 32'h0, e);
        rd(ch_addr(1, 0), d, e); chk("R8 count only on external ticks", d, 32'd16);
        rd(ch_addr(0, 0), d, e); chk("R10 other channel unchanged", d, 32'd9);

        // R12: count write takes effect directly.
        wr(ch_addr(6, 0), 32'h0000_1234, e);
        rd(ch_addr(6, 0), d, e); chk("R12 count write", d, 32'h0000_1234);

        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule